// File: doc/BRIEF.md
# Quadlet Channel Frame Tracker

This block sits on the device side of a three-wire serial media bus. The bus has a clock from the bus controller, a shared signal line and a shared data line. The block samples both lines on each rising edge of the bus clock. It waits for the 32-bit sync word that the controller sends on the signal line once per frame. The bit after that word is bit 0 of quadlet 0, so byte and slot timing is re-aligned on every frame. From then on the block counts 32-bit quadlet slots until the next sync word is due.

Each quadlet that does not carry the sync word has a 16-bit channel address in its first two signal-line bytes. That address names the owner of the data-line quadlet that follows it. Up to `NCH` logical channel addresses can be configured. A logical channel may own any set of slots, adjacent or not. When the address announced for slot N matches a configured entry, the block assembles the data line during slot N+1 and hands the whole quadlet out with its address. If a sync word is missing where one is expected, the block drops lock, flags the loss and withholds the quadlet that ended at that moment.

Top module: `qct_frame_tracker`

## Requirements
- R1: While `rst_n` is low, `locked`, `frame_start`, `sync_lost` and `q_valid` are 0, and `q_addr` and `q_data` are zero.
- R2: While unlocked, the block locks on the rising edge that samples the last bit of a 32-bit window equal to `SYNC_PAT`, taken most significant bit first from `sig_in`. The next sampled bit is bit 0 of quadlet 0.
- R3: A frame has `QPF` quadlets, and the last one carries the sync word on `sig_in`. `frame_start` is high for one cycle after a lock, and again after each sync word that arrives where it is expected.
- R4: If the last quadlet of a frame does not carry `SYNC_PAT`, then `locked` falls and `sync_lost` is high for one cycle. The data quadlet that ended on that edge is not output.
- R5: The channel address is bits 0..15 of a quadlet on `sig_in`, most significant bit first. A match delivers the next quadlet's 32 data bits, most significant bit first, as one `q_valid` cycle just after that quadlet's last bit. `q_addr` carries the matching address.
- R6: Entry i of the channel table is `chan_cfg[16*i+15:16*i]`. A match with any entry selects the slot.
- R7: The address 0x0000 never selects a slot, even when a table entry is zero.
- R8: When one address appears in several slots of a frame, adjacent or not, each of those slots produces its own output.
- R9: An address that announces the sync quadlet delivers that quadlet's data. The quadlet that follows a sync word, or follows lock, is never delivered.
- R10: `q_valid` stays low while the block is unlocked.
- R11: After a loss, a new sync word restores lock and normal delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock from the controller; both lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Sampled signal line |
| dat_in | input | 1 | Sampled data line |
| chan_cfg | input | NCH*16 | Table of logical channel addresses, entry i at bits 16*i+15..16*i |
| locked | output | 1 | Frame timing is aligned |
| frame_start | output | 1 | One-cycle strobe at each frame boundary |
| sync_lost | output | 1 | One-cycle strobe when an expected sync word is missing |
| q_valid | output | 1 | One-cycle strobe when a captured quadlet is available |
| q_addr | output | 16 | Channel address of the captured quadlet |
| q_data | output | 32 | Captured data quadlet |

## Verification
Some properties are checked on every cycle:
- `frame_start` only occurs at bit 0 of quadlet 0.
- The bit counter advances by exactly one while locked.
- A loss strobe always comes with lock released and no output.
- No quadlet is delivered while unlocked, with address zero, or in the slot right after a frame boundary.

Other behaviour only the bench scenarios can show:
- The pairing of an address with the data of the following slot.
- Repeated use of one address within a frame.
- Delivery of the sync slot's data.
- Withholding of the quadlet that ends on a missed sync.
- Relock after a gap of unlocked traffic.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int QUAD_BITS = 32;
  localparam int ADDR_BITS = 16;
  localparam int BIT_IDX_W = $clog2(QUAD_BITS);

  typedef logic [QUAD_BITS-1:0] quad_t;
  typedef logic [ADDR_BITS-1:0] addr_t;
  typedef logic [BIT_IDX_W-1:0] bidx_t;

  // Append one serial bit at the least significant end (MSB-first assembly).
  function automatic quad_t push_bit(quad_t v, logic b);
    return {v[QUAD_BITS-2:0], b};
  endfunction

  // A table entry selects an address only when it is non-zero and equal.
  function automatic logic addr_selects(addr_t entry, addr_t seen);
    return (entry != '0) && (entry == seen);
  endfunction

  function automatic logic is_bit(bidx_t idx, int pos);
    return idx == bidx_t'(pos);
  endfunction
endpackage

// File: rtl/qct_sync_det.sv
module qct_sync_det
  import qct_pkg::*;
#(
  parameter quad_t SYNC_PAT = 32'h7FFE_8001,
  parameter int    QPF      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sig_in,
  output logic                   locked,
  output bidx_t                  bit_idx,
  output logic [$clog2(QPF)-1:0] quad_idx,
  output logic                   quad_end,
  output logic                   sync_quad,
  output logic                   acquire,
  output logic                   resync,
  output logic                   miss,
  output quad_t                  sig_word
);
  localparam int QW = $clog2(QPF);

  quad_t sig_sr;
  logic  pat_hit;

  assign sig_word  = push_bit(sig_sr, sig_in);
  assign pat_hit   = (sig_word == SYNC_PAT);
  assign quad_end  = locked && is_bit(bit_idx, QUAD_BITS-1);
  assign sync_quad = (quad_idx == QW'(QPF-1));
  assign acquire   = !locked && pat_hit;
  assign resync    = quad_end && sync_quad && pat_hit;
  assign miss      = quad_end && sync_quad && !pat_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_sr   <= '0;
      locked   <= 1'b0;
      bit_idx  <= '0;
      quad_idx <= '0;
    end else begin
      sig_sr <= sig_word;
      if (acquire) begin
        locked   <= 1'b1;
        bit_idx  <= '0;
        quad_idx <= '0;
      end else if (miss) begin
        locked   <= 1'b0;
        bit_idx  <= '0;
        quad_idx <= '0;
      end else if (locked) begin
        bit_idx <= bit_idx + bidx_t'(1);
        if (quad_end) quad_idx <= sync_quad ? '0 : quad_idx + QW'(1);
      end
    end
  end
endmodule

// File: rtl/qct_addr_match.sv
module qct_addr_match
  import qct_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   locked,
  input  bidx_t                  bit_idx,
  input  addr_t                  cand,
  input  logic [NCH*ADDR_BITS-1:0] chan_cfg,
  output logic                   addr_done,
  output logic                   addr_hit,
  output addr_t                  addr_seen
);
  logic [NCH-1:0] entry_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign entry_hit[i] = addr_selects(chan_cfg[i*ADDR_BITS +: ADDR_BITS], cand);
  end

  assign addr_done = locked && is_bit(bit_idx, ADDR_BITS-1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_hit  <= 1'b0;
      addr_seen <= '0;
    end else if (addr_done) begin
      addr_hit  <= |entry_hit;
      addr_seen <= cand;
    end
  end
endmodule

// File: rtl/qct_capture.sv
module qct_capture
  import qct_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dat_in,
  input  logic  quad_end,
  input  logic  sync_quad,
  input  logic  acquire,
  input  logic  miss,
  input  logic  addr_hit,
  input  addr_t addr_seen,
  output logic  q_valid,
  output addr_t q_addr,
  output quad_t q_data
);
  quad_t dat_sr;
  quad_t dat_word;
  logic  sel_hit;
  addr_t sel_addr;

  assign dat_word = push_bit(dat_sr, dat_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_sr   <= '0;
      sel_hit  <= 1'b0;
      sel_addr <= '0;
      q_valid  <= 1'b0;
      q_addr   <= '0;
      q_data   <= '0;
    end else begin
      dat_sr  <= dat_word;
      q_valid <= 1'b0;
      if (acquire || miss) begin
        sel_hit <= 1'b0;
      end else if (quad_end) begin
        if (sel_hit) begin
          q_valid <= 1'b1;
          q_addr  <= sel_addr;
          q_data  <= dat_word;
        end
        sel_hit  <= addr_hit && !sync_quad;
        sel_addr <= addr_seen;
      end
    end
  end
endmodule

// File: rtl/qct_frame_tracker.sv
module qct_frame_tracker
  import qct_pkg::*;
#(
  parameter quad_t SYNC_PAT = 32'h7FFE_8001,
  parameter int    QPF      = 8,
  parameter int    NCH      = 4
) (
  input  logic                     bus_clk,
  input  logic                     rst_n,
  input  logic                     sig_in,
  input  logic                     dat_in,
  input  logic [NCH*ADDR_BITS-1:0] chan_cfg,
  output logic                     locked,
  output logic                     frame_start,
  output logic                     sync_lost,
  output logic                     q_valid,
  output logic [ADDR_BITS-1:0]     q_addr,
  output logic [QUAD_BITS-1:0]     q_data
);
  localparam int QW = $clog2(QPF);

  bidx_t          bit_idx;
  logic [QW-1:0]  quad_idx;
  logic           quad_end, sync_quad, acquire, resync, miss;
  quad_t          sig_word;
  logic           addr_done, addr_hit;
  addr_t          addr_seen;

  qct_sync_det #(.SYNC_PAT(SYNC_PAT), .QPF(QPF)) u_sync (
    .clk(bus_clk), .rst_n(rst_n), .sig_in(sig_in),
    .locked(locked), .bit_idx(bit_idx), .quad_idx(quad_idx),
    .quad_end(quad_end), .sync_quad(sync_quad), .acquire(acquire),
    .resync(resync), .miss(miss), .sig_word(sig_word)
  );

  qct_addr_match #(.NCH(NCH)) u_match (
    .clk(bus_clk), .rst_n(rst_n), .locked(locked), .bit_idx(bit_idx),
    .cand(sig_word[ADDR_BITS-1:0]), .chan_cfg(chan_cfg),
    .addr_done(addr_done), .addr_hit(addr_hit), .addr_seen(addr_seen)
  );

  qct_capture u_cap (
    .clk(bus_clk), .rst_n(rst_n), .dat_in(dat_in), .quad_end(quad_end),
    .sync_quad(sync_quad), .acquire(acquire), .miss(miss),
    .addr_hit(addr_hit), .addr_seen(addr_seen),
    .q_valid(q_valid), .q_addr(q_addr), .q_data(q_data)
  );

  always_ff @(posedge bus_clk) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      sync_lost   <= 1'b0;
    end else begin
      frame_start <= acquire || resync;
      sync_lost   <= miss;
    end
  end
endmodule

// File: rtl/qct_checker.sv
module qct_checker #(
  parameter int QPF = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   locked,
  input logic [4:0]             bit_idx,
  input logic [$clog2(QPF)-1:0] quad_idx,
  input logic                   frame_start,
  input logic                   sync_lost,
  input logic                   q_valid,
  input logic [15:0]            q_addr
);
  localparam int QW = $clog2(QPF);

  // R3
  fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (locked && bit_idx == 5'd0 && quad_idx == '0));

  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> (bit_idx == 5'($past(bit_idx) + 5'd1)));

  // R4
  lost_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!locked && !q_valid));

  // R10
  qv_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> $past(locked));

  // R7
  zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (q_addr != 16'h0000));

  // R9
  no_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> !(quad_idx == QW'(1) && bit_idx == 5'd0));
endmodule

bind qct_frame_tracker qct_checker #(.QPF(QPF)) u_chk (
  .clk(bus_clk), .rst_n(rst_n), .locked(locked), .bit_idx(bit_idx),
  .quad_idx(quad_idx), .frame_start(frame_start), .sync_lost(sync_lost),
  .q_valid(q_valid), .q_addr(q_addr)
);

// File: tb/sim_qct_frame_tracker.sv
`timescale 1ns/1ps
module sim_qct_frame_tracker;
  localparam logic [31:0] SYNC = 32'h7FFE_8001;
  localparam int QPF = 8;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0, dat_in = 1'b0;
  logic [NCH*16-1:0] chan_cfg;
  logic locked, frame_start, sync_lost, q_valid;
  logic [15:0] q_addr;
  logic [31:0] q_data;

  always #4 clk = ~clk;

  qct_frame_tracker #(.SYNC_PAT(SYNC), .QPF(QPF), .NCH(NCH)) u0 (
    .bus_clk(clk), .rst_n(rst_n), .sig_in(sig_in), .dat_in(dat_in),
    .chan_cfg(chan_cfg), .locked(locked), .frame_start(frame_start),
    .sync_lost(sync_lost), .q_valid(q_valid), .q_addr(q_addr), .q_data(q_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit sig_h[$], dat_h[$];
  int m_locked = 0, m_pos = 0, m_sel = 0, m_pend = 0;
  bit e_fs = 0, e_lost = 0, e_qv = 0;
  logic [15:0] e_addr = '0;
  logic [31:0] e_data = '0;

  function automatic logic [31:0] tail_word(bit q[$], int n);
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) w = {w[30:0], q[q.size()-n+k]};
    return w;
  endfunction

  function automatic bit cfg_has(logic [15:0] a);
    if (a == 16'h0) return 0;
    for (int i = 0; i < NCH; i++) if (chan_cfg[i*16 +: 16] == a) return 1;
    return 0;
  endfunction

  task automatic emit();
    if (m_sel != 0) begin
      e_qv = 1; e_addr = 16'(m_sel); e_data = tail_word(dat_h, 32);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      sig_h = {}; dat_h = {};
      for (int i = 0; i < 32; i++) begin sig_h.push_back(0); dat_h.push_back(0); end
      m_locked = 0; m_pos = 0; m_sel = 0; m_pend = 0;
      e_fs = 0; e_lost = 0; e_qv = 0;
    end else begin
      sig_h.push_back(sig_in); void'(sig_h.pop_front());
      dat_h.push_back(dat_in); void'(dat_h.pop_front());
      e_fs = 0; e_lost = 0; e_qv = 0;
      if (m_locked == 0) begin
        if (tail_word(sig_h, 32) == SYNC) begin
          m_locked = 1; m_pos = 0; m_sel = 0; e_fs = 1;
        end
      end else begin
        if (m_pos % 32 == 15) m_pend = cfg_has(tail_word(sig_h, 16)) ? int'(tail_word(sig_h, 16)) : 0;
        if (m_pos % 32 == 31) begin
          if (m_pos / 32 == QPF - 1) begin
            if (tail_word(sig_h, 32) == SYNC) begin e_fs = 1; emit(); end
            else begin e_lost = 1; m_locked = 0; end
            m_pos = 0; m_sel = 0;
          end else begin
            emit(); m_sel = m_pend; m_pos++;
          end
        end else m_pos++;
      end
    end
  end

  // ---------------- compare and log ----------------
  logic [15:0] log_addr[$];
  logic [31:0] log_data[$];
  int fs_cnt = 0, lost_cnt = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(locked == m_locked[0], "R2 lock state", 32'(locked), 32'(m_locked));
      check(frame_start == e_fs, "R3 frame strobe", 32'(frame_start), 32'(e_fs));
      check(sync_lost == e_lost, "R4 loss strobe", 32'(sync_lost), 32'(e_lost));
      check(q_valid == e_qv, "R5 quadlet strobe", 32'(q_valid), 32'(e_qv));
      if (q_valid && e_qv) begin
        check(q_data == e_data, "R5 quadlet data", q_data, e_data);
        check(q_addr == e_addr, "R6 quadlet address", 32'(q_addr), 32'(e_addr));
      end
      if (q_valid) begin log_addr.push_back(q_addr); log_data.push_back(q_data); end
      if (frame_start) fs_cnt++;
      if (sync_lost) lost_cnt++;
    end
  end

  // ---------------- stimulus ----------------
  localparam logic [15:0] PLAN [7] = '{16'h1111, 16'h0000, 16'h5555, 16'h1111,
                                       16'h2222, 16'h4444, 16'h1111};

  function automatic logic [31:0] dword(int f, int q);
    return {8'hC3, 8'(f), 8'(q), 8'h5A};
  endfunction

  task automatic send_word(input logic [31:0] s, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk); sig_in = s[i]; dat_in = d[i];
    end
  endtask

  task automatic send_frame(input int f, input bit good);
    for (int q = 0; q < QPF; q++)
      send_word((q < QPF-1) ? {PLAN[q], 16'h0000} : (good ? SYNC : 32'h0), dword(f, q));
  endtask

  function automatic int count_of(int f, int q, int a);
    int n = 0;
    for (int i = 0; i < log_data.size(); i++)
      if ((f < 0 || log_data[i][23:16] == 8'(f)) && (q < 0 || log_data[i][15:8] == 8'(q)) &&
          (a < 0 || log_addr[i] == 16'(a))) n++;
    return n;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // entry0=1111 entry1=2222 entry2=0000 entry3=4444
    chan_cfg = {16'h4444, 16'h0000, 16'h2222, 16'h1111};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(locked == 0, "R1 reset locked", 32'(locked), 0);
    check(frame_start == 0, "R1 reset frame_start", 32'(frame_start), 0);
    check(sync_lost == 0, "R1 reset sync_lost", 32'(sync_lost), 0);
    check(q_valid == 0, "R1 reset q_valid", 32'(q_valid), 0);
    check(q_data == 0 && q_addr == 0, "R1 reset data", q_data, 0);
    rst_n = 1'b1;

    send_word(32'h0, 32'h0);
    send_word(32'h0, 32'h0);
    send_word(SYNC, dword(0, 7));
    send_frame(1, 1);
    send_frame(2, 1);
    send_frame(3, 0);
    send_frame(9, 0);
    send_word(SYNC, dword(8, 7));
    send_frame(4, 1);
    send_word(32'h0, 32'h0);
    repeat (4) @(negedge clk);
    done = 1;

    // R5: address of slot 3 tags the data of slot 4
    check(count_of(1, 4, 16'h1111) == 1, "R5 pairing slot4", 32'(count_of(1, 4, 16'h1111)), 1);
    // R6: two further table entries select their slots
    check(count_of(1, 5, 16'h2222) == 1, "R6 entry1", 32'(count_of(1, 5, 16'h2222)), 1);
    check(count_of(1, 6, 16'h4444) == 1, "R6 entry3", 32'(count_of(1, 6, 16'h4444)), 1);
    // R7: zero address never delivered
    check(count_of(-1, -1, 0) == 0, "R7 zero address", 32'(count_of(-1, -1, 0)), 0);
    // R8: repeated address in non-adjacent slots
    check(count_of(1, -1, 16'h1111) == 3, "R8 repeated address", 32'(count_of(1, -1, 16'h1111)), 3);
    // R9: slot 0 never delivered, sync slot delivered
    check(count_of(-1, 0, -1) == 0, "R9 first slot", 32'(count_of(-1, 0, -1)), 0);
    check(count_of(2, 7, 16'h1111) == 1, "R9 sync slot data", 32'(count_of(2, 7, 16'h1111)), 1);
    // R4: loss detected once, quadlet ending on the miss withheld
    check(lost_cnt == 1, "R4 loss count", 32'(lost_cnt), 1);
    check(count_of(3, 7, -1) == 0, "R4 withheld quadlet", 32'(count_of(3, 7, -1)), 0);
    check(count_of(3, -1, -1) == 4, "R4 frame before loss", 32'(count_of(3, -1, -1)), 4);
    // R10: nothing while unlocked
    check(count_of(9, -1, -1) == 0, "R10 unlocked frame", 32'(count_of(9, -1, -1)), 0);
    check(count_of(8, -1, -1) == 0, "R10 relock word", 32'(count_of(8, -1, -1)), 0);
    // R11: delivery resumes after relock
    check(count_of(4, -1, -1) == 5, "R11 after relock", 32'(count_of(4, -1, -1)), 5);
    // R3: frame strobes (two locks, three good boundaries)
    check(fs_cnt == 5, "R3 frame strobe count", 32'(fs_cnt), 5);
    // R2: still locked at the end
    check(locked == 1, "R2 final lock", 32'(locked), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule